// File: doc/BRIEF.md
# I2C Crypto Command Frame Monitor

A passive monitor placed behind a bus-event decoder on a two-wire serial bus. It consumes one event per cycle (start, address with direction, data byte with direction, stop) and splits each transaction into the framing used by a crypto-authentication device. The block never drives the bus. It only reports what it saw, on a one-cycle result strobe.

For a write it reports the word address. When that address selects a command, it also reports the count, opcode, first parameter, 16-bit second parameter, the two CRC bytes, and where the payload starts and ends inside the frame. A command frame whose length disagrees with its count is flagged, and its remaining fields are suppressed. For a read it reports the response count and the trailing CRC bytes. When the preceding write makes a short status reply expected, it also reports the status byte and whether that byte is a known code. Frames longer than the capacity are flagged as overflowed.

Top module: `i2c_cmd_frame_mon`

## Requirements
- R1: Event encoding on `ev_kind_i` is 0 start, 1 address, 2 data and 3 stop. `ev_rd_i`=1 means read. A start, then an address event, opens a read or write frame, and a stop closes it. `res_valid_o` pulses for exactly one cycle, in the cycle after the stop is sampled. The result fields hold their values between pulses.
- R2: The following events are ignored and produce no pulse: data whose direction differs from the frame, any event before a start, and a stop before the address.
- R3: A write frame with no data bytes produces no pulse.
- R4: A write whose first byte is not 0x03 reports only `waddr_o` (0x00 reset, 0x01 sleep, 0x02 idle). All other fields are zero.
- R5: In a valid command write (byte0 = 0x03), the fields are taken from fixed positions:
  - byte1 is `count_o` and byte2 is `opcode_o`.
  - byte3 is `param1_o`.
  - `param2_o` is {byte5, byte4}.
  - `crc_o` is {second-to-last byte, last byte}.
- R6: In a valid command write of n bytes, `pay_start_o`=6, `pay_end_o`=n-2 (exclusive) and `pay_len_o`=n-8.
- R7: A command write is valid only when count equals n-1 and n is at least 8. Otherwise `len_err_o`=1, and only `waddr_o` and `count_o` are non-zero.
- R8: A read reports byte0 as `count_o` and its last two bytes as `crc_o`. The status path is taken when the stored word address is 0x00, or when it is 0x03 and byte0 is 4. On the status path, `stat_valid_o`=1 and `stat_o` is byte1.
- R9: `stat_known_o`=1 only on the status path, and only when the status byte is one of 0x00, 0x01, 0x03, 0x0F, 0x11 or 0xFF.
- R10: Each parsed read clears the stored word address. A non-empty write without overflow stores its first byte. An overflowed write leaves the stored address unchanged.
- R11: If a frame carries more than BUF_DEPTH matching data bytes, the result has `ovf_o`=1 and every field except `res_rd_o` is zero.
- R12: A start during a frame discards the partial frame, and the monitor waits for a new address.
- R13: While `rst_ni` is low, the monitor goes idle, forgets the stored word address and zeroes every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ev_valid_i | input | 1 | event present this cycle |
| ev_kind_i | input | 2 | event kind |
| ev_rd_i | input | 1 | direction of address/data event, 1 = read |
| ev_byte_i | input | 8 | data byte |
| res_valid_o | output | 1 | one-cycle result strobe |
| res_rd_o | output | 1 | result is from a read frame |
| waddr_o | output | 8 | word address |
| count_o | output | 8 | count byte |
| opcode_o | output | 8 | opcode |
| param1_o | output | 8 | first parameter |
| param2_o | output | 16 | second parameter |
| crc_o | output | 16 | CRC bytes, first received in high half |
| pay_start_o | output | CW | payload start index |
| pay_end_o | output | CW | payload end index, exclusive |
| pay_len_o | output | CW | payload length |
| len_err_o | output | 1 | count/length mismatch |
| ovf_o | output | 1 | frame exceeded capacity |
| stat_valid_o | output | 1 | status byte present |
| stat_o | output | 8 | status byte |
| stat_known_o | output | 1 | status byte is a defined code |

## Verification
Internal faults show up at the ports within one frame:
- A wrong state-machine state drops or adds a result strobe at the cycle after the next stop.
- A byte-counter error moves the payload offsets, or raises a spurious length error, on the very next command frame.
- A wrong stored word address shows up only one transaction later, as a status path taken or missed on the following read.

For that reason the benches pair each write with a read and replay reads back to back. The bench's reference model is compared with every output on every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam logic [1:0] EV_START = 2'd0;
  localparam logic [1:0] EV_ADDR  = 2'd1;
  localparam logic [1:0] EV_DATA  = 2'd2;
  localparam logic [1:0] EV_STOP  = 2'd3;

  localparam logic [7:0] WA_RESET = 8'h00;
  localparam logic [7:0] WA_CMD   = 8'h03;
  localparam logic [7:0] STAT_LEN = 8'd4;
  localparam int unsigned HDR_N   = 6;

  typedef struct packed {
    logic       is_rd;
    logic [7:0] waddr;
    logic [7:0] count;
    logic [7:0] opcode;
    logic [7:0] param1;
    logic [15:0] param2;
    logic [15:0] crc;
    logic       len_err;
    logic       ovf;
    logic       st_valid;
    logic [7:0] status;
    logic       st_known;
  } res_t;

  function automatic logic code_known(input logic [7:0] c);
    return (c == 8'h00) || (c == 8'h01) || (c == 8'h03) ||
           (c == 8'h0F) || (c == 8'h11) || (c == 8'hFF);
  endfunction
endpackage

// File: rtl/mon_fsm.sv
module mon_fsm
  import mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_valid_i,
  input  logic [1:0] ev_kind_i,
  input  logic       ev_rd_i,
  output logic       open_o,
  output logic       take_o,
  output logic       done_o,
  output logic       dir_rd_o
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_RD, S_WR} st_e;
  st_e st_q, st_d;

  logic in_frame;
  assign in_frame = (st_q == S_RD) || (st_q == S_WR);
  assign dir_rd_o = (st_q == S_RD);
  assign open_o   = ev_valid_i && (st_q == S_ADDR) && (ev_kind_i == EV_ADDR);
  assign done_o   = ev_valid_i && in_frame && (ev_kind_i == EV_STOP);
  assign take_o   = ev_valid_i && (ev_kind_i == EV_DATA) &&
                    (((st_q == S_RD) && ev_rd_i) || ((st_q == S_WR) && !ev_rd_i));

  always_comb begin
    st_d = st_q;
    if (ev_valid_i) begin
      unique case (st_q)
        S_IDLE: if (ev_kind_i == EV_START) st_d = S_ADDR;
        S_ADDR: begin
          if (ev_kind_i == EV_ADDR)      st_d = ev_rd_i ? S_RD : S_WR;
          else if (ev_kind_i == EV_STOP) st_d = S_IDLE;
        end
        default: begin
          if (ev_kind_i == EV_STOP)       st_d = S_IDLE;
          else if (ev_kind_i == EV_START) st_d = S_ADDR; // restart drops frame
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
endmodule

// File: rtl/mon_capture.sv
module mon_capture
  import mon_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 80,
  parameter int unsigned CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 take_i,
  input  logic [7:0]           byte_i,
  output logic [CW-1:0]        n_o,
  output logic                 ovf_o,
  output logic [HDR_N-1:0][7:0] hdr_o,
  output logic [15:0]          tail_o
);
  localparam logic [CW-1:0] FULL = CW'(BUF_DEPTH);

  logic full;
  assign full = (n_o == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_o <= '0; ovf_o <= 1'b0; tail_o <= '0;
    end else if (clr_i) begin
      n_o <= '0; ovf_o <= 1'b0; tail_o <= '0;
    end else if (take_i) begin
      if (full) ovf_o <= 1'b1;
      else      n_o   <= n_o + 1'b1;
      tail_o <= {tail_o[7:0], byte_i};
    end
  end

  for (genvar g = 0; g < HDR_N; g++) begin : g_hdr
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (clr_i)                             q <= '0;
      else if (take_i && !full && n_o == CW'(g))  q <= byte_i;
    end
    assign hdr_o[g] = q;
  end
endmodule

// File: rtl/mon_parse.sv
module mon_parse
  import mon_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  done_i,
  input  logic                  dir_rd_i,
  input  logic [CW-1:0]         n_i,
  input  logic                  ovf_i,
  input  logic [HDR_N-1:0][7:0] hdr_i,
  input  logic [15:0]           tail_i,
  output logic                  valid_o,
  output res_t                  res_o,
  output logic [CW-1:0]         pay_start_o,
  output logic [CW-1:0]         pay_end_o,
  output logic [CW-1:0]         pay_len_o
);
  localparam int unsigned LW = (CW > 8) ? CW + 1 : 9;

  logic       known_q;
  logic [7:0] kw_q;
  res_t       nx;
  logic [CW-1:0] ps_d, pe_d, pl_d;
  logic       emit, wr_store, len_ok, st_path;
  logic [LW-1:0] n_x, cnt_x;

  assign n_x     = LW'(n_i);
  assign cnt_x   = LW'(hdr_i[1]);
  assign len_ok  = (n_x == cnt_x + LW'(1)) && (n_x >= LW'(8));
  assign st_path = known_q && ((kw_q == WA_RESET) ||
                               ((kw_q == WA_CMD) && (hdr_i[0] == STAT_LEN)));
  assign emit     = done_i && (dir_rd_i || ovf_i || (n_i != '0));
  assign wr_store = done_i && !dir_rd_i && !ovf_i && (n_i != '0);

  always_comb begin
    nx = '0;
    ps_d = '0; pe_d = '0; pl_d = '0;
    nx.is_rd = dir_rd_i;
    if (ovf_i) begin
      nx.ovf = 1'b1;
    end else if (dir_rd_i) begin
      nx.count    = hdr_i[0];
      nx.crc      = tail_i;
      nx.st_valid = st_path;
      nx.status   = st_path ? hdr_i[1] : 8'h00;
      nx.st_known = st_path && code_known(hdr_i[1]);
    end else begin
      nx.waddr = hdr_i[0];
      if (hdr_i[0] == WA_CMD) begin
        nx.count = hdr_i[1];
        if (len_ok) begin
          nx.opcode = hdr_i[2];
          nx.param1 = hdr_i[3];
          nx.param2 = {hdr_i[5], hdr_i[4]};
          nx.crc    = tail_i;
          ps_d = CW'(6);
          pe_d = n_i - CW'(2);
          pl_d = n_i - CW'(8);
        end else begin
          nx.len_err = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; res_o <= '0;
      pay_start_o <= '0; pay_end_o <= '0; pay_len_o <= '0;
      known_q <= 1'b0; kw_q <= '0;
    end else begin
      valid_o <= emit;
      if (emit) begin
        res_o <= nx;
        pay_start_o <= ps_d; pay_end_o <= pe_d; pay_len_o <= pl_d;
      end
      if (done_i && dir_rd_i) known_q <= 1'b0;
      else if (wr_store) begin
        known_q <= 1'b1;
        kw_q    <= hdr_i[0];
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_frame_mon.sv
module i2c_cmd_frame_mon
  import mon_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 80,
  parameter int unsigned CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_valid_i,
  input  logic [1:0]    ev_kind_i,
  input  logic          ev_rd_i,
  input  logic [7:0]    ev_byte_i,
  output logic          res_valid_o,
  output logic          res_rd_o,
  output logic [7:0]    waddr_o,
  output logic [7:0]    count_o,
  output logic [7:0]    opcode_o,
  output logic [7:0]    param1_o,
  output logic [15:0]   param2_o,
  output logic [15:0]   crc_o,
  output logic [CW-1:0] pay_start_o,
  output logic [CW-1:0] pay_end_o,
  output logic [CW-1:0] pay_len_o,
  output logic          len_err_o,
  output logic          ovf_o,
  output logic          stat_valid_o,
  output logic [7:0]    stat_o,
  output logic          stat_known_o
);
  logic open_w, take_w, done_w, dir_rd_w, ovf_w;
  logic [CW-1:0] n_w;
  logic [HDR_N-1:0][7:0] hdr_w;
  logic [15:0] tail_w;
  res_t res_w;

  mon_fsm u_fsm (
    .clk_i, .rst_ni, .ev_valid_i, .ev_kind_i, .ev_rd_i,
    .open_o(open_w), .take_o(take_w), .done_o(done_w), .dir_rd_o(dir_rd_w)
  );

  mon_capture #(.BUF_DEPTH(BUF_DEPTH), .CW(CW)) u_cap (
    .clk_i, .rst_ni, .clr_i(open_w), .take_i(take_w), .byte_i(ev_byte_i),
    .n_o(n_w), .ovf_o(ovf_w), .hdr_o(hdr_w), .tail_o(tail_w)
  );

  mon_parse #(.CW(CW)) u_parse (
    .clk_i, .rst_ni, .done_i(done_w), .dir_rd_i(dir_rd_w), .n_i(n_w),
    .ovf_i(ovf_w), .hdr_i(hdr_w), .tail_i(tail_w),
    .valid_o(res_valid_o), .res_o(res_w),
    .pay_start_o, .pay_end_o, .pay_len_o
  );

  assign res_rd_o     = res_w.is_rd;
  assign waddr_o      = res_w.waddr;
  assign count_o      = res_w.count;
  assign opcode_o     = res_w.opcode;
  assign param1_o     = res_w.param1;
  assign param2_o     = res_w.param2;
  assign crc_o        = res_w.crc;
  assign len_err_o    = res_w.len_err;
  assign ovf_o        = res_w.ovf;
  assign stat_valid_o = res_w.st_valid;
  assign stat_o       = res_w.status;
  assign stat_known_o = res_w.st_known;
endmodule

// File: rtl/i2c_cmd_frame_mon_chk.sv
module i2c_cmd_frame_mon_chk #(
  parameter int unsigned CW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ev_valid_i,
  input logic [1:0]    ev_kind_i,
  input logic          res_valid_o,
  input logic          res_rd_o,
  input logic [7:0]    waddr_o,
  input logic [7:0]    opcode_o,
  input logic [CW-1:0] pay_start_o,
  input logic [CW-1:0] pay_end_o,
  input logic [CW-1:0] pay_len_o,
  input logic          len_err_o,
  input logic          ovf_o,
  input logic          stat_valid_o
);
  p_after_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(ev_valid_i && ev_kind_i == 2'd3));
  p_one_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(waddr_o) && $stable(pay_len_o));
  p_len_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && len_err_o |-> opcode_o == 8'h00 && pay_len_o == '0);
  p_ovf_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && ovf_o |-> !len_err_o && !stat_valid_o && waddr_o == 8'h00);
  p_status_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && stat_valid_o |-> res_rd_o);
  p_pay_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_rd_o && !len_err_o && !ovf_o && waddr_o == 8'h03
      |-> pay_len_o == pay_end_o - pay_start_o);
endmodule

bind i2c_cmd_frame_mon i2c_cmd_frame_mon_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_i2c_cmd_frame_mon.sv
module sim_i2c_cmd_frame_mon;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 80;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_rd = 0;
  logic [1:0] ev_kind = 0;
  logic [7:0] ev_byte = 0;
  logic res_valid, res_rd, len_err, ovf, st_valid, st_known;
  logic [7:0] waddr, count, opcode, param1, status;
  logic [15:0] param2, crc;
  logic [CW-1:0] ps, pe, pl;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_frame_mon #(.BUF_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_rd_i(ev_rd), .ev_byte_i(ev_byte), .res_valid_o(res_valid), .res_rd_o(res_rd),
    .waddr_o(waddr), .count_o(count), .opcode_o(opcode), .param1_o(param1),
    .param2_o(param2), .crc_o(crc), .pay_start_o(ps), .pay_end_o(pe), .pay_len_o(pl),
    .len_err_o(len_err), .ovf_o(ovf), .stat_valid_o(st_valid), .stat_o(status),
    .stat_known_o(st_known));

  int n_chk = 0, n_fail = 0, pulses = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mst = 0;
  int q[$];
  bit m_ov = 0, m_known = 0;
  int m_kw = 0;
  bit e_valid = 0, e_rd = 0, e_le = 0, e_ov = 0, e_sv = 0, e_sk = 0;
  int e_wa = 0, e_cnt = 0, e_op = 0, e_p1 = 0, e_p2 = 0, e_crc = 0;
  int e_st = 0, e_ps = 0, e_pe = 0, e_pl = 0;

  function automatic int bq(int i);
    return (q.size() > i) ? q[i] : 0;
  endfunction

  task automatic clear_exp();
    e_rd = 0; e_le = 0; e_ov = 0; e_sv = 0; e_sk = 0;
    e_wa = 0; e_cnt = 0; e_op = 0; e_p1 = 0; e_p2 = 0; e_crc = 0;
    e_st = 0; e_ps = 0; e_pe = 0; e_pl = 0;
  endtask

  task automatic finish_frame(bit rd);
    int n = q.size();
    if (!rd && !m_ov && n == 0) return;
    e_valid = 1; clear_exp(); e_rd = rd;
    if (m_ov) begin
      e_ov = 1;
    end else if (rd) begin
      e_cnt = bq(0);
      e_crc = ((n >= 2 ? bq(n-2) : 0) << 8) | (n >= 1 ? bq(n-1) : 0);
      e_sv = m_known && (m_kw == 0 || (m_kw == 3 && bq(0) == 4));
      e_st = e_sv ? bq(1) : 0;
      e_sk = e_sv && (e_st inside {8'h00, 8'h01, 8'h03, 8'h0F, 8'h11, 8'hFF});
    end else begin
      e_wa = bq(0);
      if (e_wa == 3) begin
        e_cnt = bq(1);
        if (n - 1 == bq(1) && n >= 8) begin
          e_op = bq(2); e_p1 = bq(3); e_p2 = (bq(5) << 8) | bq(4);
          e_crc = (bq(n-2) << 8) | bq(n-1);
          e_ps = 6; e_pe = n - 2; e_pl = n - 8;
        end else e_le = 1;
      end
    end
    if (rd) m_known = 0;
    else if (!m_ov) begin m_known = 1; m_kw = bq(0); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; q.delete(); m_ov = 0; m_known = 0; e_valid = 0; clear_exp();
    end else begin
      e_valid = 0;
      if (ev_valid) begin
        case (mst)
          0: if (ev_kind == 0) mst = 1;
          1: if (ev_kind == 1) begin mst = ev_rd ? 2 : 3; q.delete(); m_ov = 0; end
             else if (ev_kind == 3) mst = 0;
          default: begin
            if (ev_kind == 3) begin finish_frame(mst == 2); mst = 0; end
            else if (ev_kind == 0) mst = 1;
            else if (ev_kind == 2 && (ev_rd == (mst == 2))) begin
              if (q.size() < DEPTH) q.push_back(int'(ev_byte)); else m_ov = 1;
            end
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) pulses++;
      chk("R1 res_valid", res_valid, e_valid);
      chk("R1 res_rd", res_rd, e_rd);
      chk("R4 waddr", waddr, e_wa);
      chk("R5 count", count, e_cnt);
      chk("R5 opcode", opcode, e_op);
      chk("R5 param1", param1, e_p1);
      chk("R5 param2", param2, e_p2);
      chk("R5 crc", crc, e_crc);
      chk("R6 pay_start", ps, e_ps);
      chk("R6 pay_end", pe, e_pe);
      chk("R6 pay_len", pl, e_pl);
      chk("R7 len_err", len_err, e_le);
      chk("R11 ovf", ovf, e_ov);
      chk("R8 stat_valid", st_valid, e_sv);
      chk("R8 stat", status, e_st);
      chk("R9 stat_known", st_known, e_sk);
    end
  end

  // stimulus
  task automatic ev(input int k, input bit rd, input int b);
    @(negedge clk);
    ev_valid = 1; ev_kind = 2'(k); ev_rd = rd; ev_byte = 8'(b);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic frame(input bit rd, input int bytes[$]);
    ev(0, 0, 0); ev(1, rd, 0);
    foreach (bytes[i]) ev(2, rd, bytes[i]);
    ev(3, 0, 0);
    repeat (2) @(negedge clk);
  endtask

  function automatic void cmd_q(ref int b[$], input int op, input int plen);
    b = '{3, plen + 7, op, 8'h5A, 8'h34, 8'h12};
    for (int i = 0; i < plen; i++) b.push_back((i * 7 + 1) & 8'hFF);
    b.push_back(8'hC1); b.push_back(8'hC2);
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b[$];
    int p0;
    repeat (3) @(negedge clk);
    chk("R13 reset res_valid", res_valid, 0);
    chk("R13 reset waddr", waddr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cmd_q(b, 8'h1B, 0); frame(0, b);
    chk("R5 opcode short cmd", opcode, 8'h1B);
    chk("R5 param2 lsb first", param2, 16'h1234);
    chk("R6 empty payload", pl, 0);

    cmd_q(b, 8'h08, 32); frame(0, b);
    chk("R6 pay_len 32", pl, 32);
    chk("R6 pay_end", pe, 38);
    chk("R5 crc", crc, 16'hC1C2);

    frame(1, '{4, 8'h11, 8'hAA, 8'hBB});
    chk("R8 status after cmd", st_valid, 1);
    chk("R9 ready known", st_known, 1);
    frame(1, '{4, 8'h11, 8'hAA, 8'hBB});
    chk("R10 cleared after read", st_valid, 0);

    frame(0, '{0});
    chk("R4 reset waddr", waddr, 0);
    chk("R4 other zero", count, 0);
    frame(1, '{4, 8'h22, 1, 2});
    chk("R8 status after reset waddr", st_valid, 1);
    chk("R9 unknown code", st_known, 0);

    frame(0, '{3, 10, 1, 2, 3, 4, 5, 6});
    chk("R7 count mismatch", len_err, 1);
    chk("R7 count kept", count, 10);
    frame(0, '{3, 4, 8'hAB, 8'hCD, 8'hEF});
    chk("R7 too short", len_err, 1);

    frame(0, '{2});
    chk("R4 idle waddr", waddr, 2);

    p0 = pulses;
    frame(0, '{});
    chk("R3 wake-up no pulse", pulses, p0);

    p0 = pulses;
    ev(2, 0, 8'h55); ev(3, 0, 0);
    ev(0, 0, 0); ev(3, 0, 0);
    repeat (2) @(negedge clk);
    chk("R2 stray events", pulses, p0);
    ev(0, 0, 0); ev(1, 0, 0); ev(2, 0, 1); ev(2, 1, 8'h77); ev(3, 0, 0);
    repeat (2) @(negedge clk);
    chk("R2 wrong direction byte", waddr, 1);

    ev(0, 0, 0); ev(1, 0, 0); ev(2, 0, 0); ev(2, 0, 9);
    cmd_q(b, 8'h16, 4); frame(0, b);
    chk("R12 restart opcode", opcode, 8'h16);
    chk("R12 restart pay_len", pl, 4);

    b.delete();
    b.push_back(1);
    for (int i = 0; i < DEPTH + 1; i++) b.push_back(i & 8'hFF);
    frame(0, b);
    chk("R11 overflow flag", ovf, 1);
    chk("R11 overflow waddr zero", waddr, 0);
    frame(1, '{4, 8'h0F, 0, 0});
    chk("R10 ovf keeps stored cmd", st_valid, 1);
    chk("R9 exec error known", st_known, 1);

    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R13 reset clears fields", opcode, 0);
    rst_n = 1;
    frame(1, '{4, 0, 0, 0});
    chk("R13 stored waddr forgotten", st_valid, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule